// File: doc/BRIEF.md
# Serial Bus Loopback and Resynchronisation Controller

This block sits beside the data-link engine of a single-wire serial bus. It holds three control bits: analog loopback, digital loopback and wait-clock stop. It steers the digital transmit and receive paths to match them. While analog loopback is set, the bus driver is switched off and the link layer hears its own transmit bit. Digital loopback connects the transmit bit straight back to the receive input, whatever the analog bit holds.

When analog loopback is cleared, traffic does not start again at once. The block watches the bus and counts consecutive idle clock ticks. Reception is allowed after an end-of-frame idle time (`EOF_TICKS`). Transmission is allowed after a longer inter-frame idle time (`IFS_TICKS`). Any active bus level during the wait sets the count back to zero. Setting analog loopback again cancels the wait.

The block also produces the clock enable for the link layer, which can be stopped while the CPU is in wait mode.

Top module: `lpbk_resync_ctl`

## Requirements
- R1: After reset the register reads 0x03 (bit0 analog loopback = 1, bit1 digital loopback = 1, bit2 wait-clock stop = 0). In this state bus_drive_en, rx_allow and tx_allow are 0 and clk_en is 1.
- R2: A write with reg_we high stores wdata[2:0] into bit0 analog loopback, bit1 digital loopback and bit2 wait-clock stop. From the next cycle reg_rdata returns those bits unchanged. Bits [7:3] are ignored and always read 0.
- R3: While digital loopback is 1, ll_rx equals tx_raw in the same cycle, and phy_rx has no effect on it.
- R4: While analog loopback is 1, bus_drive_en is 0 and ll_rx equals tx_raw.
- R5: While both loopback bits are 0, bus_drive_en is 1 and ll_rx equals phy_rx.
- R6: With analog loopback 0, rx_allow rises at the clock edge that samples the EOF_TICKS-th consecutive idle cycle (phy_rx = 0).
- R7: With analog loopback 0, tx_allow rises at the clock edge that samples the IFS_TICKS-th consecutive idle cycle. IFS_TICKS must exceed EOF_TICKS.
- R8: An active cycle (phy_rx = 1) before the thresholds are reached restarts the idle count from zero. Once rx_allow or tx_allow is 1, it stays 1 until analog loopback is set again.
- R9: In the cycle after analog loopback is written to 1, rx_allow and tx_allow are 0. A later clear starts a fresh idle count.
- R10: clk_en is 0 while cpu_wait and wait-clock stop are both 1, and 1 otherwise. While clk_en is 0, the idle count does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back |
| tx_raw | input | 1 | Transmit bit from the link layer |
| phy_rx | input | 1 | Receive bit from the physical interface, 1 = active |
| cpu_wait | input | 1 | CPU is in wait mode |
| bus_drive_en | output | 1 | Enables the bus output driver |
| ll_rx | output | 1 | Receive bit delivered to the link layer |
| rx_allow | output | 1 | Reception permitted |
| tx_allow | output | 1 | Transmission permitted |
| clk_en | output | 1 | Clock enable for the link layer |

## Verification
On every cycle the assertions check the routing of the receive path in digital loopback, the gating of the clock in wait mode, and that both allow flags are held off during analog loopback. They also check that transmission is never allowed without reception, that the allow flags are sticky, and that the flags are frozen while the clock is gated. Only the bench's scenarios can show the exact cycle on which each threshold is crossed. The same holds for the restart of the count after a burst of bus activity in mid-wait, and for cancelling a wait by setting analog loopback again. The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/lpbk_resync_ctl.sv
module lpbk_resync_ctl #(
  parameter int EOF_TICKS = 12,
  parameter int IFS_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_raw,
  input  logic       phy_rx,
  input  logic       cpu_wait,
  output logic       bus_drive_en,
  output logic       ll_rx,
  output logic       rx_allow,
  output logic       tx_allow,
  output logic       clk_en
);
  localparam int CW = $clog2(IFS_TICKS + 1);
  localparam logic [CW-1:0] EOF_C = CW'(EOF_TICKS);
  localparam logic [CW-1:0] IFS_C = CW'(IFS_TICKS);

  logic          alb_q, dlb_q, wcs_q;
  logic          rx_ok, tx_ok;
  logic [CW-1:0] idle_cnt, idle_nxt;

  assign reg_rdata    = {5'b0, wcs_q, dlb_q, alb_q};
  assign bus_drive_en = ~alb_q;
  assign ll_rx        = (dlb_q | alb_q) ? tx_raw : phy_rx;
  assign clk_en       = ~(cpu_wait & wcs_q);
  assign rx_allow     = rx_ok & ~alb_q;
  assign tx_allow     = tx_ok & ~alb_q;
  assign idle_nxt     = phy_rx ? '0 : (idle_cnt == IFS_C ? idle_cnt : idle_cnt + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alb_q <= 1'b1;
      dlb_q <= 1'b1;
      wcs_q <= 1'b0;
    end else if (reg_we) begin
      alb_q <= reg_wdata[0];
      dlb_q <= reg_wdata[1];
      wcs_q <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      rx_ok    <= 1'b0;
      tx_ok    <= 1'b0;
    end else if (alb_q) begin
      idle_cnt <= '0;
      rx_ok    <= 1'b0;
      tx_ok    <= 1'b0;
    end else if (clk_en && !tx_ok) begin
      idle_cnt <= idle_nxt;
      if (idle_nxt >= EOF_C) rx_ok <= 1'b1;
      if (idle_nxt >= IFS_C) tx_ok <= 1'b1;
    end
  end
endmodule

module lpbk_resync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       tx_raw,
  input logic       phy_rx,
  input logic       cpu_wait,
  input logic       ll_rx,
  input logic       rx_allow,
  input logic       tx_allow,
  input logic       clk_en
);
  p_dlb_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |-> (ll_rx == tx_raw));
  p_loop_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] |-> (!rx_allow && !tx_allow));
  p_tx_needs_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_allow |-> rx_allow);
  p_rx_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_allow |=> (rx_allow || reg_rdata[0]));
  p_tx_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_allow |=> (tx_allow || reg_rdata[0]));
  p_rise_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_allow) |-> $past(!phy_rx));
  p_wait_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && reg_rdata[2]) |-> !clk_en);
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !reg_we) |=> ($stable(rx_allow) && $stable(tx_allow)));
endmodule

bind lpbk_resync_ctl lpbk_resync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .tx_raw(tx_raw), .phy_rx(phy_rx), .cpu_wait(cpu_wait), .ll_rx(ll_rx),
  .rx_allow(rx_allow), .tx_allow(tx_allow), .clk_en(clk_en)
);

// File: tb/sim_lpbk_resync_ctl.sv
`timescale 1ns/1ps
module sim_lpbk_resync_ctl;
  localparam int EOF_T = 12;
  localparam int IFS_T = 20;

  logic clk = 0, rst_n = 0, reg_we = 0, tx_raw = 0, phy_rx = 0, cpu_wait = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_drive_en, ll_rx, rx_allow, tx_allow, clk_en;
  int checks = 0, failures = 0;
  bit done = 0;

  bit m_alb = 1, m_dlb = 1, m_wcs = 0, m_rx = 0, m_tx = 0;
  int m_idle = 0;

  lpbk_resync_ctl #(.EOF_TICKS(EOF_T), .IFS_TICKS(IFS_T)) u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_alb = 1; m_dlb = 1; m_wcs = 0; m_idle = 0; m_rx = 0; m_tx = 0;
    end else begin
      if (m_alb) begin
        m_idle = 0; m_rx = 0; m_tx = 0;
      end else if (!(cpu_wait && m_wcs) && !m_tx) begin
        m_idle = phy_rx ? 0 : m_idle + 1;
        if (m_idle >= EOF_T) m_rx = 1;
        if (m_idle >= IFS_T) m_tx = 1;
      end
      if (reg_we) begin
        m_alb = reg_wdata[0]; m_dlb = reg_wdata[1]; m_wcs = reg_wdata[2];
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 rdata", reg_rdata, {5'b0, m_wcs, m_dlb, m_alb});
      chk(m_alb ? "R4 drive" : "R5 drive", bus_drive_en, !m_alb);
      chk(m_dlb ? "R3 ll_rx" : (m_alb ? "R4 ll_rx" : "R5 ll_rx"), ll_rx,
          (m_dlb || m_alb) ? tx_raw : phy_rx);
      chk("R6 rx_allow", rx_allow, m_rx && !m_alb);
      chk("R7 tx_allow", tx_allow, m_tx && !m_alb);
      chk("R10 clk_en", clk_en, !(cpu_wait && m_wcs));
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic idle(input int n, input bit mix);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); phy_rx = 0; tx_raw = mix ? ~tx_raw : tx_raw;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 rdata", reg_rdata, 8'h03);
    chk("R1 drive", bus_drive_en, 0);
    chk("R1 rx_allow", rx_allow, 0);
    chk("R1 tx_allow", tx_allow, 0);
    chk("R1 clk_en", clk_en, 1);
    // R3: both loopbacks, phy activity must not reach ll_rx
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); tx_raw = i[0]; phy_rx = ~i[1];
    end
    wr(8'h01);  // R4: analog loopback only
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); tx_raw = i[1]; phy_rx = i[0];
    end
    wr(8'h02);  // R3 with analog cleared, start idle wait
    idle(IFS_T + 3, 1);
    #1; chk("R7 tx after idle", tx_allow, 1);
    wr(8'h00);  // R5 routing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); phy_rx = i[0]; tx_raw = ~i[0];
    end
    #1; chk("R8 tx sticky", tx_allow, 1);
    wr(8'h01);
    #1; chk("R9 rx cancelled", rx_allow, 0);
    chk("R9 tx cancelled", tx_allow, 0);
    wr(8'h00);
    idle(EOF_T - 3, 0);
    @(negedge clk); phy_rx = 1;
    idle(EOF_T - 1, 0);
    #1; chk("R8 restart holds rx", rx_allow, 0);
    idle(4, 0);
    #1; chk("R6 rx after restart", rx_allow, 1);
    @(negedge clk); phy_rx = 1;
    @(negedge clk); phy_rx = 0;
    #1; chk("R8 rx sticky", rx_allow, 1);
    chk("R8 tx still off", tx_allow, 0);
    wr(8'h01); wr(8'h04);
    idle(5, 0);
    @(negedge clk); cpu_wait = 1;
    idle(IFS_T + 5, 0);
    #1; chk("R10 frozen rx", rx_allow, 0);
    chk("R10 gated", clk_en, 0);
    @(negedge clk); cpu_wait = 0;
    idle(IFS_T, 0);
    #1; chk("R7 tx after wake", tx_allow, 1);
    wr(8'hF8);
    #1; chk("R2 upper ignored", reg_rdata, 8'h00);
    wr(8'hFF);
    #1; chk("R2 readback", reg_rdata, 8'h07);
    idle(4, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule